// File: doc/BRIEF.md
# Single-Cycle Shift and Rotate Unit

This block moves an 8-bit operand left or right by any distance from 0 to 7 bit positions and registers the outcome on the next rising clock edge. The positions that the move leaves empty are filled from a source chosen by a 3-bit mode field. The sources are:

- the bits pushed out of the far end (plain rotate);
- constant zeros;
- constant ones;
- a carry flag joined to the operand as a ninth bit (rotate through carry);
- copies of the operand's top bit (arithmetic shift right).

A carry-out is registered beside the result. It holds the last bit pushed out of the word, or the incoming carry when the distance is zero.

The datapath is a logarithmic barrel with one stage per bit of the distance field. Each stage moves by a power of two. Right moves reuse the same left-moving barrel: the operand is bit-reversed before the barrel and the result is reversed again after it. Typical uses are field extraction, byte-half swaps, walking a one-hot probe around a word, and mixing steps in checksum or hash logic.

Top module: `shiftrot_unit`

## Requirements
- R1: While `rst_n` is low, `result_o` and `carry_o` are both 0.
- R2: Inputs present at a rising clock edge produce their `result_o` and `carry_o` right after that same edge, for every distance 0 to 7.
- R3: Mode code 0 rotates. Each bit leaving one end re-enters at the other end. For a nonzero distance k, `carry_o` is the last bit that left: `data_i[8-k]` when moving left, `data_i[k-1]` when moving right.
- R4: Mode code 1 fills the vacated positions with 0, and `carry_o` follows the last-exited rule of R3.
- R5: Mode code 2 fills the vacated positions with 1, and `carry_o` follows the last-exited rule of R3.
- R6: Mode code 3 rotates the 9-bit value {`carry_i`, `data_i`} with the carry as its top bit. Afterwards `carry_o` is the top bit and `result_o` is the low 8 bits. Moving right therefore feeds `carry_i` into bit 7.
- R7: Mode code 4 copies `data_i[7]` into the vacated positions when moving right, and fills with 0 when moving left. `carry_o` follows R3.
- R8: A distance of 0 gives `result_o` = `data_i` and `carry_o` = `carry_i`, in every mode and both directions.
- R9: `dir_i` = 0 selects a move toward the MSB (left) and `dir_i` = 1 a move toward the LSB (right).
- R10: In mode 0, a distance of 4 (half the width) swaps the upper and lower nibbles in either direction.
- R11: Unused mode codes 5, 6 and 7 behave exactly like mode code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Operand |
| amt_i | input | 3 | Distance, 0 to 7 |
| dir_i | input | 1 | 0 = left, 1 = right |
| mode_i | input | 3 | Fill source: 0 rotate, 1 zeros, 2 ones, 3 through carry, 4 sign; 5 to 7 as 1 |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 8 | Registered result |
| carry_o | output | 1 | Registered carry-out |

## Verification
There is exactly one register between the inputs and both outputs. A vector applied before a rising edge is therefore due on `result_o` and `carry_o` as soon as that edge has passed, and nothing is due earlier or later. The bench drives each vector on a falling edge and compares the outputs at the following falling edge. At that point exactly one rising edge has gone by and the next vector has not yet been captured. The sweep covers every operand, distance, direction, carry value and all eight mode codes, one vector per cycle. The assertions also compare each output with the inputs captured one cycle earlier through `$past`.

// File: rtl/shiftrot_pkg.sv
package shiftrot_pkg;

   // Mode field encoding at the block's edge.
   typedef enum logic [2:0] {
      SR_ROT  = 3'd0,
      SR_ZERO = 3'd1,
      SR_ONE  = 3'd2,
      SR_RCC  = 3'd3,
      SR_SIGN = 3'd4
   } sr_mode_e;

   // What a barrel stage writes into its vacated low positions.
   typedef enum logic [1:0] {
      FILL_WRAP       = 2'd0,   // bits from the top of the word
      FILL_WRAP_CARRY = 2'd1,   // carry, then top bits (9-bit ring)
      FILL_CONST      = 2'd2    // a single constant bit
   } sr_fill_e;

endpackage

// File: rtl/shiftrot_orient.sv
// Optional bit reversal, so that one left-moving barrel serves both directions.
module shiftrot_orient #(
   parameter int W = 8
) (
   input  logic         flip,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] rev;

   for (genvar i = 0; i < W; i++) begin : g_rev
      assign rev[i] = d[W-1-i];
   end

   assign q = flip ? rev : d;
endmodule

// File: rtl/shiftrot_fill_ctrl.sv
// Maps mode and direction to the fill behaviour used by every barrel stage.
module shiftrot_fill_ctrl import shiftrot_pkg::*; (
   input  logic [2:0] mode,
   input  logic       dir_right,
   input  logic       sign_bit,
   output sr_fill_e   fill_kind,
   output logic       fill_bit
);
   always_comb begin
      fill_kind = FILL_CONST;
      fill_bit  = 1'b0;
      case (mode)
         SR_ROT:  fill_kind = FILL_WRAP;
         SR_RCC:  fill_kind = FILL_WRAP_CARRY;
         SR_ONE:  fill_bit  = 1'b1;
         SR_SIGN: fill_bit  = dir_right & sign_bit;
         default: fill_bit  = 1'b0;
      endcase
   end
endmodule

// File: rtl/shiftrot_stage.sv
// One barrel stage: a conditional left move by the fixed distance SHIFT.
// The carry slot sits above bit W-1, so a 9-bit ring needs no extra stage.
module shiftrot_stage import shiftrot_pkg::*; #(
   parameter int W     = 8,
   parameter int SHIFT = 1
) (
   input  logic         en,
   input  sr_fill_e     fill_kind,
   input  logic         fill_bit,
   input  logic [W-1:0] d_in,
   input  logic         c_in,
   output logic [W-1:0] d_out,
   output logic         c_out
);
   logic [W-1:0] moved;

   if (SHIFT < 1 || SHIFT >= W) begin : g_bad_shift
      $error("shiftrot_stage: SHIFT must lie in 1..W-1");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= SHIFT) begin : g_body
         assign moved[i] = d_in[i-SHIFT];
      end else begin : g_vac
         logic ring9;
         if (i == SHIFT - 1) begin : g_carry_in
            assign ring9 = c_in;
         end else begin : g_top_in
            assign ring9 = d_in[i-SHIFT+W+1];
         end
         assign moved[i] = (fill_kind == FILL_WRAP)       ? d_in[i-SHIFT+W] :
                           (fill_kind == FILL_WRAP_CARRY) ? ring9 :
                                                            fill_bit;
      end
   end

   assign d_out = en ? moved : d_in;
   assign c_out = en ? d_in[W-SHIFT] : c_in;
endmodule

// File: rtl/shiftrot_barrel.sv
// Logarithmic chain of stages, stage k moving by 2**k when amt[k] is set.
module shiftrot_barrel import shiftrot_pkg::*; #(
   parameter  int W     = 8,
   localparam int AMT_W = $clog2(W)
) (
   input  logic [AMT_W-1:0] amt,
   input  sr_fill_e         fill_kind,
   input  logic             fill_bit,
   input  logic [W-1:0]     d_in,
   input  logic             c_in,
   output logic [W-1:0]     d_out,
   output logic             c_out
);
   logic [W-1:0] d_chain [0:AMT_W];
   logic         c_chain [0:AMT_W];

   assign d_chain[0] = d_in;
   assign c_chain[0] = c_in;

   for (genvar k = 0; k < AMT_W; k++) begin : g_stage
      shiftrot_stage #(
         .W     (W),
         .SHIFT (1 << k)
      ) u_stage (
         .en        (amt[k]),
         .fill_kind (fill_kind),
         .fill_bit  (fill_bit),
         .d_in      (d_chain[k]),
         .c_in      (c_chain[k]),
         .d_out     (d_chain[k+1]),
         .c_out     (c_chain[k+1])
      );
   end

   assign d_out = d_chain[AMT_W];
   assign c_out = c_chain[AMT_W];
endmodule

// File: rtl/shiftrot_unit.sv
module shiftrot_unit import shiftrot_pkg::*; #(
   parameter  int DATA_W = 8,
   localparam int AMT_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] data_i,
   input  logic [AMT_W-1:0]  amt_i,
   input  logic              dir_i,
   input  logic [2:0]        mode_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o
);
   if (DATA_W < 2 || (1 << AMT_W) != DATA_W) begin : g_bad_width
      $error("shiftrot_unit: DATA_W must be a power of two of at least 2");
   end

   sr_fill_e          fill_kind;
   logic              fill_bit;
   logic [DATA_W-1:0] oriented;
   logic [DATA_W-1:0] moved;
   logic [DATA_W-1:0] restored;
   logic              carry_nx;

   shiftrot_fill_ctrl u_fill (
      .mode      (mode_i),
      .dir_right (dir_i),
      .sign_bit  (data_i[DATA_W-1]),
      .fill_kind (fill_kind),
      .fill_bit  (fill_bit)
   );

   shiftrot_orient #(.W(DATA_W)) u_orient_in (
      .flip (dir_i),
      .d    (data_i),
      .q    (oriented)
   );

   shiftrot_barrel #(.W(DATA_W)) u_barrel (
      .amt       (amt_i),
      .fill_kind (fill_kind),
      .fill_bit  (fill_bit),
      .d_in      (oriented),
      .c_in      (carry_i),
      .d_out     (moved),
      .c_out     (carry_nx)
   );

   shiftrot_orient #(.W(DATA_W)) u_orient_out (
      .flip (dir_i),
      .d    (moved),
      .q    (restored)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o <= '0;
         carry_o  <= 1'b0;
      end else begin
         result_o <= restored;
         carry_o  <= carry_nx;
      end
   end

   // R8
   amt_zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (amt_i == '0) |=> (result_o == $past(data_i) && carry_o == $past(carry_i)));

   // R3
   rot_popcount_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == SR_ROT) |=> ($countones(result_o) == $countones($past(data_i))));

   // R6
   rcc_popcount_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == SR_RCC) |=>
         ($countones({carry_o, result_o}) == $countones($past({carry_i, data_i}))));

   // R4
   zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == SR_ZERO && amt_i != '0) |=>
         ($countones(result_o) <= $countones($past(data_i))));

   // R5
   one_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == SR_ONE && amt_i != '0) |=>
         ($countones(result_o) >= $countones($past(data_i))));

   // R7
   sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == SR_SIGN && dir_i) |=> (result_o[DATA_W-1] == $past(data_i[DATA_W-1])));
endmodule

// File: tb/shiftrot_unit_tb.sv
module shiftrot_unit_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] data_i = '0;
   logic [2:0] amt_i = '0;
   logic       dir_i = 1'b0;
   logic [2:0] mode_i = '0;
   logic       carry_i = 1'b0;
   logic [7:0] result_o;
   logic       carry_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   shiftrot_unit #(.DATA_W(8)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_i   (data_i),
      .amt_i    (amt_i),
      .dir_i    (dir_i),
      .mode_i   (mode_i),
      .carry_i  (carry_i),
      .result_o (result_o),
      .carry_o  (carry_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%03h expected=%03h", tag, act, exp);
      end
   endtask

   // Expected {carry, result} worked out from the requirements.
   function automatic int model(int d, int k, int dir, int mode, int c);
      int v, r, co, mask;
      bit fill;
      if (k == 0) return (c << 8) | d;                      // R8
      if (mode == 3) begin                                  // R6
         v = (c << 8) | d;
         if (dir == 0) v = ((v << k) | (v >> (9 - k))) & 511;
         else          v = ((v >> k) | (v << (9 - k))) & 511;
         return v;
      end
      co = (dir == 0) ? ((d >> (8 - k)) & 1) : ((d >> (k - 1)) & 1);
      if (mode == 0) begin                                  // R3
         if (dir == 0) r = ((d << k) | (d >> (8 - k))) & 255;
         else          r = ((d >> k) | (d << (8 - k))) & 255;
      end else begin                                        // R4 R5 R7 R11
         fill = (mode == 2) || (mode == 4 && dir == 1 && d >= 128);
         mask = (dir == 0) ? ((1 << k) - 1) : ((255 << (8 - k)) & 255);
         r    = (dir == 0) ? ((d << k) & 255) : (d >> k);
         if (fill) r = r | mask;
      end
      return (co << 8) | r;
   endfunction

   function automatic string tag_of(int k, int mode);
      if (k == 0) return "R8";
      case (mode)
         0: return (k == 4) ? "R10" : "R3";
         1: return "R4";
         2: return "R5";
         3: return "R6";
         4: return "R7";
         default: return "R11";
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1: outputs cleared while held in reset
      repeat (3) @(negedge clk);
      data_i = 8'hA5; amt_i = 3'd3; carry_i = 1'b1; mode_i = 3'd2;
      @(negedge clk);
      check("R1 reset result", int'(result_o), 0);
      check("R1 reset carry",  int'(carry_o),  0);
      rst_n = 1'b1;

      // R2 R9: one vector per cycle over the whole input space
      for (int mode = 0; mode < 8; mode++) begin
         for (int dir = 0; dir < 2; dir++) begin
            for (int k = 0; k < 8; k++) begin
               for (int c = 0; c < 2; c++) begin
                  for (int d = 0; d < 256; d++) begin
                     data_i  = 8'(d);
                     amt_i   = 3'(k);
                     dir_i   = 1'(dir);
                     mode_i  = 3'(mode);
                     carry_i = 1'(c);
                     @(negedge clk);
                     check($sformatf("%s R2 R9 mode=%0d dir=%0d amt=%0d cin=%0d data=%02h",
                                     tag_of(k, mode), mode, dir, k, c, d),
                           {23'd0, carry_o, result_o}, model(d, k, dir, mode, c));
                  end
               end
            end
         end
      end

      // R10: nibble swap spelled out directly
      data_i = 8'h3C; amt_i = 3'd4; mode_i = 3'd0; dir_i = 1'b1; carry_i = 1'b0;
      @(negedge clk);
      check("R10 half rotate swap", int'(result_o), 'hC3);

      // R1: reset asserted again mid-run clears the outputs at once
      data_i = 8'hFF; amt_i = 3'd1; mode_i = 3'd2; dir_i = 1'b0; carry_i = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 mid-run reset result", int'(result_o), 0);
      check("R1 mid-run reset carry",  int'(carry_o),  0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule